// File: doc/BRIEF.md
# Streaming gate unit

This block lets a processor core treat message streams as if they were registers. It has two input gates and two output gates. Each gate is a view onto one logical channel, and a small binding register for each gate picks that channel. The binding can be rewritten while traffic is flowing. Every channel has its own receive queue, which the link side fills, and its own send queue, which the link side drains. Reading an input gate takes the oldest word from the receive queue of the channel bound to it. Writing an output gate appends a word to the send queue of the channel bound to it.

The core presents one access at a time: a valid strobe, a direction, a gate index and write data. If the bound queue cannot serve the access, because a receive queue is empty or a send queue is full, the unit raises stall in the same cycle. The core then holds the request unchanged. The access completes in the first cycle in which stall is low. A four-bit status word shows, for each gate, whether an access would go through without waiting.

Top module: `stream_gate_unit`

## Requirements
- R1: After reset every receive queue and send queue is empty, so `rx_full` is all zeros and `tx_empty` is all ones. `gate_status` reads 4'b1100 and `acc_stall` is low. Input gate g and output gate g are each bound to channel g.
- R2: A read (`acc_valid`=1, `acc_write`=0) of input gate `acc_gate` whose bound receive queue holds data is accepted in that cycle and removes the oldest word. That word appears on `acc_rdata` one cycle after the accepting edge and stays there until the next accepted read.
- R3: A read of an input gate whose bound receive queue is empty drives `acc_stall` high in the same cycle. Once a word is pushed into that queue at an edge, stall goes low in the next cycle and the read completes with that word.
- R4: An accepted write (`acc_write`=1) to output gate `acc_gate` appends `acc_wdata` to the bound channel's send queue, and `tx_empty` for that channel clears one cycle later. A link pop (`tx_rd_en` with `tx_rd_chan`) takes the oldest word of that queue and shows it on `tx_rd_data` one cycle after the edge.
- R5: A write to an output gate whose bound send queue is full holds `acc_stall` high. The write completes in the cycle after a link pop frees a slot.
- R6: `bind_we` loads `bind_chan` into the binding register selected by `bind_idx`. The encoding is 0 for input gate 0, 1 for input gate 1, 2 for output gate 0 and 3 for output gate 1. An access in the same cycle as the bind write still uses the old channel; the new channel applies from the next cycle.
- R7: Two gates of the same direction bound to one channel share that channel's queue, so reads that alternate between them return the words in push order.
- R8: `gate_status` bit g (g = 0, 1) is 1 when the receive queue bound to input gate g is not empty. Bit 2+g is 1 when the send queue bound to output gate g is not full.
- R9: Each queue holds Q_DEPTH words in first-in first-out order. A link push (`rx_wr_en`) into a full receive queue is dropped and `rx_full` stays high.
- R10: With `acc_valid` low, `acc_stall` is low whatever the queues hold. A link pop from an empty send queue leaves `tx_rd_data` and `tx_empty` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Core gate access request |
| acc_write | input | 1 | 1 = write an output gate, 0 = read an input gate |
| acc_gate | input | 1 | Gate index within the chosen direction |
| acc_wdata | input | DATA_W | Word to write |
| acc_rdata | output | DATA_W | Word from the last accepted read |
| acc_stall | output | 1 | Access cannot complete this cycle |
| bind_we | input | 1 | Binding register write strobe |
| bind_idx | input | 2 | Binding register selector (0,1 input gates; 2,3 output gates) |
| bind_chan | input | CH_W | Channel to bind |
| gate_status | output | 4 | Per-gate ready bits |
| rx_wr_en | input | 1 | Link pushes a received word |
| rx_wr_chan | input | CH_W | Channel of the received word |
| rx_wr_data | input | DATA_W | Received word |
| rx_full | output | NUM_CH | Receive queue full, per channel |
| tx_rd_en | input | 1 | Link pops a word to send |
| tx_rd_chan | input | CH_W | Channel to pop |
| tx_rd_data | output | DATA_W | Word from the last successful link pop |
| tx_empty | output | NUM_CH | Send queue empty, per channel |

## Verification
Stall and the selection it depends on are combinational, so the bench reads `acc_stall` just after it drives a request at the falling edge. Read data, link pop data, `gate_status`, `rx_full` and `tx_empty` all change at the edge that accepts an operation. The bench therefore samples them at the falling edge that follows that rising edge, one cycle after the stimulus. For stalled accesses the bench counts the falling edges at which stall was high. Each stall test pushes or pops a word three cycles after the request, so the expected count is exactly four.

// File: rtl/sgu_pkg.sv
package sgu_pkg;
  localparam int GATES_PER_DIR = 2;

  typedef enum logic [1:0] {
    GATE_IN0  = 2'd0,
    GATE_IN1  = 2'd1,
    GATE_OUT0 = 2'd2,
    GATE_OUT1 = 2'd3
  } gate_id_e;
endpackage

// File: rtl/sgu_fifo.sv
module sgu_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt;
  logic          push_ok, pop_ok;

  assign empty   = (cnt == '0);
  assign full    = (cnt == DEPTH_V);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  // storage without reset so a block RAM can hold it
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst)         dout <= '0;
    else if (pop_ok) dout <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/sgu_bind_regs.sv
module sgu_bind_regs
  import sgu_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 2
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               bind_we,
  input  logic [1:0]                         bind_idx,
  input  logic [CW-1:0]                      bind_chan,
  output logic [GATES_PER_DIR-1:0][CW-1:0]   in_chan,
  output logic [GATES_PER_DIR-1:0][CW-1:0]   out_chan
);
  localparam logic [CW:0] NCH_V = (CW+1)'(NCH);

  logic chan_ok;
  assign chan_ok = ({1'b0, bind_chan} < NCH_V);

  for (genvar g = 0; g < GATES_PER_DIR; g++) begin : g_bind
    localparam logic [CW-1:0] RST_CH = CW'(g % NCH);
    localparam logic [1:0] IN_ID  = (g == 0) ? GATE_IN0  : GATE_IN1;
    localparam logic [1:0] OUT_ID = (g == 0) ? GATE_OUT0 : GATE_OUT1;

    always_ff @(posedge clk) begin
      if (rst) begin
        in_chan[g]  <= RST_CH;
        out_chan[g] <= RST_CH;
      end else if (bind_we && chan_ok) begin
        if (bind_idx == IN_ID)  in_chan[g]  <= bind_chan;
        if (bind_idx == OUT_ID) out_chan[g] <= bind_chan;
      end
    end
  end
endmodule

// File: rtl/sgu_gate_sel.sv
module sgu_gate_sel
  import sgu_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 2,
  parameter int W   = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             acc_valid,
  input  logic                             acc_write,
  input  logic                             acc_gate,
  input  logic [GATES_PER_DIR-1:0][CW-1:0] in_chan,
  input  logic [GATES_PER_DIR-1:0][CW-1:0] out_chan,
  input  logic [NCH-1:0]                   rx_empty,
  input  logic [NCH-1:0]                   tx_full,
  input  logic [NCH-1:0][W-1:0]            rx_dout,
  output logic                             acc_stall,
  output logic [NCH-1:0]                   rx_pop,
  output logic [NCH-1:0]                   tx_push,
  output logic [2*GATES_PER_DIR-1:0]       gate_status,
  output logic [W-1:0]                     acc_rdata
);
  logic [CW-1:0] sel_chan;
  logic [CW-1:0] rd_chan_q;
  logic          blocked;
  logic          accept;

  always_comb begin
    sel_chan  = acc_write ? out_chan[acc_gate] : in_chan[acc_gate];
    blocked   = acc_write ? tx_full[sel_chan] : rx_empty[sel_chan];
    acc_stall = acc_valid && blocked;
    accept    = acc_valid && !blocked;
    rx_pop    = '0;
    tx_push   = '0;
    if (accept) begin
      if (acc_write) tx_push[sel_chan] = 1'b1;
      else           rx_pop[sel_chan]  = 1'b1;
    end
  end

  for (genvar g = 0; g < GATES_PER_DIR; g++) begin : g_stat
    assign gate_status[g]               = !rx_empty[in_chan[g]];
    assign gate_status[GATES_PER_DIR+g] = !tx_full[out_chan[g]];
  end

  // remember which queue the last accepted read came from
  always_ff @(posedge clk) begin
    if (rst)                         rd_chan_q <= '0;
    else if (accept && !acc_write)   rd_chan_q <= sel_chan;
  end

  assign acc_rdata = rx_dout[rd_chan_q];
endmodule

// File: rtl/stream_gate_unit.sv
module stream_gate_unit
  import sgu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int NUM_CH  = 4,
  parameter int Q_DEPTH = 4,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_gate,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              acc_stall,
  input  logic              bind_we,
  input  logic [1:0]        bind_idx,
  input  logic [CH_W-1:0]   bind_chan,
  output logic [3:0]        gate_status,
  input  logic              rx_wr_en,
  input  logic [CH_W-1:0]   rx_wr_chan,
  input  logic [DATA_W-1:0] rx_wr_data,
  output logic [NUM_CH-1:0] rx_full,
  input  logic              tx_rd_en,
  input  logic [CH_W-1:0]   tx_rd_chan,
  output logic [DATA_W-1:0] tx_rd_data,
  output logic [NUM_CH-1:0] tx_empty
);
  logic [GATES_PER_DIR-1:0][CH_W-1:0] in_chan, out_chan;
  logic [NUM_CH-1:0]              rx_empty, tx_full, rx_pop, tx_push;
  logic [NUM_CH-1:0][DATA_W-1:0]  rx_dout, tx_dout;
  logic [CH_W-1:0]                tx_chan_q;
  logic                           tx_pop_ok;

  sgu_bind_regs #(.NCH(NUM_CH), .CW(CH_W)) u_bind (
    .clk      (clk),
    .rst      (rst),
    .bind_we  (bind_we),
    .bind_idx (bind_idx),
    .bind_chan(bind_chan),
    .in_chan  (in_chan),
    .out_chan (out_chan)
  );

  sgu_gate_sel #(.NCH(NUM_CH), .CW(CH_W), .W(DATA_W)) u_sel (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_gate   (acc_gate),
    .in_chan    (in_chan),
    .out_chan   (out_chan),
    .rx_empty   (rx_empty),
    .tx_full    (tx_full),
    .rx_dout    (rx_dout),
    .acc_stall  (acc_stall),
    .rx_pop     (rx_pop),
    .tx_push    (tx_push),
    .gate_status(gate_status),
    .acc_rdata  (acc_rdata)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic rx_hit, tx_hit;
    assign rx_hit = rx_wr_en && (rx_wr_chan == CH_W'(c));
    assign tx_hit = tx_rd_en && (tx_rd_chan == CH_W'(c));

    sgu_fifo #(.W(DATA_W), .DEPTH(Q_DEPTH)) u_rxq (
      .clk  (clk),
      .rst  (rst),
      .push (rx_hit),
      .din  (rx_wr_data),
      .pop  (rx_pop[c]),
      .dout (rx_dout[c]),
      .empty(rx_empty[c]),
      .full (rx_full[c])
    );

    sgu_fifo #(.W(DATA_W), .DEPTH(Q_DEPTH)) u_txq (
      .clk  (clk),
      .rst  (rst),
      .push (tx_push[c]),
      .din  (acc_wdata),
      .pop  (tx_hit),
      .dout (tx_dout[c]),
      .empty(tx_empty[c]),
      .full (tx_full[c])
    );
  end

  assign tx_pop_ok = tx_rd_en && !tx_empty[tx_rd_chan];

  always_ff @(posedge clk) begin
    if (rst)            tx_chan_q <= '0;
    else if (tx_pop_ok) tx_chan_q <= tx_rd_chan;
  end

  assign tx_rd_data = tx_dout[tx_chan_q];
endmodule

// File: rtl/stream_gate_unit_chk.sv
module stream_gate_unit_chk #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 acc_valid,
  input logic                 acc_write,
  input logic                 acc_gate,
  input logic                 acc_stall,
  input logic [3:0]           gate_status,
  input logic                 tx_rd_en,
  input logic [NUM_CH-1:0]    tx_empty,
  input logic [1:0][CH_W-1:0] out_chan
);
  logic            wr_done;
  logic            wr_done_q;
  logic [CH_W-1:0] wr_chan_q;

  assign wr_done = acc_valid && acc_write && !acc_stall;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_done_q <= 1'b0;
      wr_chan_q <= '0;
    end else begin
      wr_done_q <= wr_done;
      wr_chan_q <= out_chan[acc_gate];
    end
  end

  assert_idle_no_stall_R10: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |-> !acc_stall);

  assert_read_stall_empty_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write && acc_stall) |-> !gate_status[{1'b0, acc_gate}]);

  assert_write_stall_full_R5: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write && acc_stall) |-> !gate_status[{1'b1, acc_gate}]);

  assert_push_lands_R4: assert property (@(posedge clk) disable iff (rst)
    wr_done_q |-> !tx_empty[wr_chan_q]);

  assert_tx_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (!wr_done && !tx_rd_en) |=> $stable(tx_empty));
endmodule

bind stream_gate_unit stream_gate_unit_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .acc_valid  (acc_valid),
  .acc_write  (acc_write),
  .acc_gate   (acc_gate),
  .acc_stall  (acc_stall),
  .gate_status(gate_status),
  .tx_rd_en   (tx_rd_en),
  .tx_empty   (tx_empty),
  .out_chan   (out_chan)
);

// File: tb/stream_gate_unit_tb.sv
`timescale 1ns/1ps
module stream_gate_unit_tb;
  localparam int DATA_W = 8;
  localparam int NUM_CH = 4;
  localparam int DEPTH  = 4;
  localparam int CH_W   = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              acc_valid = 0, acc_write = 0, acc_gate = 0;
  logic [DATA_W-1:0] acc_wdata = '0;
  logic [DATA_W-1:0] acc_rdata;
  logic              acc_stall;
  logic              bind_we = 0;
  logic [1:0]        bind_idx = '0;
  logic [CH_W-1:0]   bind_chan = '0;
  logic [3:0]        gate_status;
  logic              rx_wr_en = 0;
  logic [CH_W-1:0]   rx_wr_chan = '0;
  logic [DATA_W-1:0] rx_wr_data = '0;
  logic [NUM_CH-1:0] rx_full;
  logic              tx_rd_en = 0;
  logic [CH_W-1:0]   tx_rd_chan = '0;
  logic [DATA_W-1:0] tx_rd_data;
  logic [NUM_CH-1:0] tx_empty;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  stream_gate_unit #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .Q_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_gate(acc_gate),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_stall(acc_stall),
    .bind_we(bind_we), .bind_idx(bind_idx), .bind_chan(bind_chan),
    .gate_status(gate_status),
    .rx_wr_en(rx_wr_en), .rx_wr_chan(rx_wr_chan), .rx_wr_data(rx_wr_data),
    .rx_full(rx_full),
    .tx_rd_en(tx_rd_en), .tx_rd_chan(tx_rd_chan), .tx_rd_data(tx_rd_data),
    .tx_empty(tx_empty)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_bind(input int idx, input int ch);
    bind_we = 1; bind_idx = 2'(idx); bind_chan = CH_W'(ch);
    tick();
    bind_we = 0;
  endtask

  task automatic link_push(input int ch, input int d);
    rx_wr_en = 1; rx_wr_chan = CH_W'(ch); rx_wr_data = DATA_W'(d);
    tick();
    rx_wr_en = 0;
  endtask

  task automatic link_pop(input int ch, output int d);
    tx_rd_en = 1; tx_rd_chan = CH_W'(ch);
    tick();
    tx_rd_en = 0;
    #1 d = int'(tx_rd_data);
  endtask

  task automatic core_read(input int g, output int d, output int stalls);
    acc_valid = 1; acc_write = 0; acc_gate = g[0]; stalls = 0;
    #1;
    while (acc_stall) begin
      stalls++;
      tick();
      #1;
    end
    tick();
    acc_valid = 0;
    #1 d = int'(acc_rdata);
  endtask

  task automatic core_write(input int g, input int d, output int stalls);
    acc_valid = 1; acc_write = 1; acc_gate = g[0]; acc_wdata = DATA_W'(d); stalls = 0;
    #1;
    while (acc_stall) begin
      stalls++;
      tick();
      #1;
    end
    tick();
    acc_valid = 0; acc_write = 0;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    int d, s, p;
    repeat (3) tick();
    rst = 0;
    #1;
    // R1 reset state
    chk("R1 stall", int'(acc_stall), 0);
    chk("R1 status", int'(gate_status), 12);
    chk("R1 rx_full", int'(rx_full), 0);
    chk("R1 tx_empty", int'(tx_empty), 15);

    // R2 / R6 / R8 sweep over channels and input gates
    for (int c = 0; c < NUM_CH; c++) begin
      for (int g = 0; g < 2; g++) begin
        do_bind(g, c);
        for (int k = 0; k < 3; k++) link_push(c, c*16 + g*4 + k);
        #1 chk("R8 in status set", int'(gate_status[g]), 1);
        for (int k = 0; k < 3; k++) begin
          core_read(g, d, s);
          chk("R2 read data", d, c*16 + g*4 + k);
          chk("R2 no stall", s, 0);
        end
        chk("R8 in status clear", int'(gate_status[g]), 0);
      end
    end

    // R3 stall on empty, released by a link push
    do_bind(0, 1);
    fork
      core_read(0, d, s);
      begin repeat (3) @(negedge clk); link_push(1, 8'h77); end
    join
    chk("R3 stall cycles", s, 4);
    chk("R3 data", d, 8'h77);

    // R9 overflow of a receive queue
    do_bind(0, 2);
    for (int k = 0; k < 5; k++) link_push(2, 8'h20 + k);
    #1 chk("R9 rx_full", int'(rx_full[2]), 1);
    for (int k = 0; k < 4; k++) begin
      core_read(0, d, s);
      chk("R9 order", d, 8'h20 + k);
    end
    chk("R9 fifth word dropped", int'(gate_status[0]), 0);

    // R4 sweep over channels and output gates
    for (int c = 0; c < NUM_CH; c++) begin
      for (int g = 0; g < 2; g++) begin
        do_bind(2 + g, c);
        core_write(g, 8'h80 + c*8 + g*2, s);
        core_write(g, 8'h81 + c*8 + g*2, s);
        chk("R4 tx_empty clear", int'(tx_empty[c]), 0);
        link_pop(c, d);
        chk("R4 pop first", d, 8'h80 + c*8 + g*2);
        link_pop(c, d);
        chk("R4 pop second", d, 8'h81 + c*8 + g*2);
        chk("R4 tx_empty set", int'(tx_empty[c]), 1);
      end
    end

    // R5 stall on full send queue
    do_bind(2, 1);
    for (int k = 0; k < 4; k++) core_write(0, 8'h40 + k, s);
    chk("R8 out status full", int'(gate_status[2]), 0);
    fork
      core_write(0, 8'h44, s);
      begin repeat (3) @(negedge clk); link_pop(1, p); end
    join
    chk("R5 stall cycles", s, 4);
    chk("R5 popped head", p, 8'h40);
    for (int k = 1; k < 5; k++) begin
      link_pop(1, d);
      chk("R5 drain order", d, 8'h40 + k);
    end

    // R7 two input gates sharing one channel
    do_bind(0, 1);
    do_bind(1, 1);
    for (int k = 0; k < 4; k++) link_push(1, 8'hC0 + k);
    for (int k = 0; k < 4; k++) begin
      core_read(k % 2, d, s);
      chk("R7 shared order", d, 8'hC0 + k);
    end

    // R6 bind write in the same cycle as an access uses the old binding
    do_bind(0, 0);
    link_push(0, 8'hA5);
    link_push(3, 8'h5A);
    bind_we = 1; bind_idx = 2'd0; bind_chan = 2'd3;
    acc_valid = 1; acc_write = 0; acc_gate = 0;
    #1 chk("R6 no stall", int'(acc_stall), 0);
    tick();
    bind_we = 0; acc_valid = 0;
    #1 chk("R6 old binding", int'(acc_rdata), 8'hA5);
    core_read(0, d, s);
    chk("R6 new binding", d, 8'h5A);

    // R10 idle request and pop from an empty send queue
    acc_valid = 0; acc_write = 0; acc_gate = 0;
    #1 chk("R10 idle stall", int'(acc_stall), 0);
    p = int'(tx_rd_data);
    link_pop(0, d);
    chk("R10 empty pop data", d, p);
    chk("R10 empty pop flag", int'(tx_empty[0]), 1);

    report();
  end
endmodule